// File: doc/BRIEF.md
# DMA Stream Address Generator

This block produces the two transfer addresses for one DMA stream. It has a peripheral-side pointer and a memory-side pointer. A start pulse loads both pointers from base-address inputs and captures the configuration for each port. After that, each port's pointer moves only when that port reports a finished beat. On a finished beat the pointer either holds its value or post-increments by the data size captured for that port.

The peripheral pointer has one extra mode, a fixed 32-bit stride. In that mode the next peripheral address is the current one with its two low bits cleared, plus four, whatever the peripheral data size. The memory pointer never uses this mode and always steps by its own size.

The block carries no data, so it has no valid/ready interface. Start and beat strobes are single-cycle control pulses with no back-pressure: every strobe seen at a clock edge takes effect at that edge. Both addresses come straight from registers.

Top module: `dma_stream_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both address outputs read 0. The captured configuration is cleared, so increment is off for both ports until the first start.
- R2: A start pulse loads the peripheral and memory base inputs into the two pointers, visible from the next cycle. When a start and a beat strobe arrive in the same cycle, the start wins.
- R3: Increment enables, size fields and the fixed-stride bit are captured only at a start. Changes on those inputs between starts have no effect on later beats.
- R4: With a port's increment enable clear, that port's address stays constant across any number of beats.
- R5: With increment enabled, a beat advances the port's address by 1, 2 or 4 for size codes 2'b00 (byte), 2'b01 (half-word) and 2'b10 (word).
- R6: Size code 2'b11 is reserved. A beat on a port captured with that code leaves its address unchanged, including in fixed-stride mode.
- R7: With peripheral increment enabled and the fixed-stride bit set, a peripheral beat sets the address to (address with bits [1:0] cleared) + 4, for any non-reserved peripheral size.
- R8: The fixed-stride bit never changes the memory address step. It also has no effect on the peripheral address when peripheral increment is disabled.
- R9: A beat on one port leaves the other port's address unchanged. Beats on both ports in the same cycle update each pointer by its own rule.
- R10: Address arithmetic wraps modulo 2^32 with no other effect.
- R11: Updates come after the beat. During the cycle a beat strobe is high, the output still shows the pre-beat address, and the new address appears the next cycle. With no start and no beat, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load both pointers and capture configuration |
| per_base_i | input | 32 | Peripheral base address loaded at start |
| mem_base_i | input | 32 | Memory base address loaded at start |
| per_inc_i | input | 1 | Peripheral increment enable |
| per_size_i | input | 2 | Peripheral data size code |
| per_fixed4_i | input | 1 | Peripheral fixed 32-bit stride select |
| mem_inc_i | input | 1 | Memory increment enable |
| mem_size_i | input | 2 | Memory data size code |
| per_beat_i | input | 1 | Peripheral beat finished |
| mem_beat_i | input | 1 | Memory beat finished |
| per_addr_o | output | 32 | Current peripheral address |
| mem_addr_o | output | 32 | Current memory address |

## Verification
Every result of this block is due exactly one clock after the strobe that causes it. A start shows its base addresses in the next cycle, a beat shows the stepped address in the next cycle, and in the strobe's own cycle the output still holds the old value. The bench keeps a behavioural model that it advances at each rising edge from the inputs it drove on the previous falling edge. It compares both addresses one nanosecond after that edge, once the registers have settled. Directed checks sample at the falling edge after the strobe is dropped. One check samples while the strobe is still high, to confirm that the update happens after the beat.

// File: rtl/dsag_pkg.sv
package dsag_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } beat_size_e;

  typedef struct packed {
    logic       inc_en;
    beat_size_e size;
    logic       fixed4;
  } port_cfg_t;

  localparam port_cfg_t CFG_IDLE = '{inc_en: 1'b0, size: SZ_BYTE, fixed4: 1'b0};

endpackage

// File: rtl/dsag_step.sv
module dsag_step
  import dsag_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic [AW-1:0] cur_i,
  input  port_cfg_t     cfg_i,
  output logic [AW-1:0] nxt_o
);

  localparam logic [AW-1:0] STRIDE = AW'(1) << ALIGN_LOG2;

  logic [AW-1:0] base;
  logic [AW-1:0] step;

  always_comb begin
    base = cur_i;
    unique case (cfg_i.size)
      SZ_BYTE: step = AW'(1);
      SZ_HALF: step = AW'(2);
      SZ_WORD: step = AW'(4);
      default: step = '0;
    endcase
    if (cfg_i.fixed4 && cfg_i.size != SZ_RSVD) begin
      base = {cur_i[AW-1:ALIGN_LOG2], {ALIGN_LOG2{1'b0}}};
      step = STRIDE;
    end
    if (!cfg_i.inc_en) begin
      base = cur_i;
      step = '0;
    end
    nxt_o = base + step;
  end

endmodule

// File: rtl/dsag_ptr.sv
module dsag_ptr
  import dsag_pkg::*;
#(
  parameter int AW        = 32,
  parameter bit HAS_FIXED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  port_cfg_t     cfg_i,
  input  logic          beat_i,
  output logic [AW-1:0] addr_o
);

  port_cfg_t     cfg_q;
  port_cfg_t     cfg_in;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;

  generate
    if (HAS_FIXED) begin : g_fixed
      assign cfg_in = cfg_i;
    end else begin : g_plain
      assign cfg_in = '{inc_en: cfg_i.inc_en, size: cfg_i.size, fixed4: 1'b0};
    end
  endgenerate

  dsag_step #(.AW(AW), .ALIGN_LOG2(2)) u_step (
    .cur_i (addr_q),
    .cfg_i (cfg_q),
    .nxt_o (addr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_IDLE;
      addr_q <= '0;
    end else if (start_i) begin
      cfg_q  <= cfg_in;
      addr_q <= base_i;
    end else if (beat_i) begin
      addr_q <= addr_nxt;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_stream_addr_gen.sv
module dma_stream_addr_gen
  import dsag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] per_base_i,
  input  logic [AW-1:0] mem_base_i,
  input  logic          per_inc_i,
  input  logic [1:0]    per_size_i,
  input  logic          per_fixed4_i,
  input  logic          mem_inc_i,
  input  logic [1:0]    mem_size_i,
  input  logic          per_beat_i,
  input  logic          mem_beat_i,
  output logic [AW-1:0] per_addr_o,
  output logic [AW-1:0] mem_addr_o
);

  port_cfg_t per_cfg;
  port_cfg_t mem_cfg;

  assign per_cfg = '{inc_en: per_inc_i, size: beat_size_e'(per_size_i), fixed4: per_fixed4_i};
  assign mem_cfg = '{inc_en: mem_inc_i, size: beat_size_e'(mem_size_i), fixed4: 1'b0};

  dsag_ptr #(.AW(AW), .HAS_FIXED(1'b1)) u_per_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .base_i  (per_base_i),
    .cfg_i   (per_cfg),
    .beat_i  (per_beat_i),
    .addr_o  (per_addr_o)
  );

  dsag_ptr #(.AW(AW), .HAS_FIXED(1'b0)) u_mem_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .base_i  (mem_base_i),
    .cfg_i   (mem_cfg),
    .beat_i  (mem_beat_i),
    .addr_o  (mem_addr_o)
  );

endmodule

// File: rtl/dsag_chk.sv
module dsag_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] per_base_i,
  input logic [AW-1:0] mem_base_i,
  input logic          per_beat_i,
  input logic          mem_beat_i,
  input logic [AW-1:0] per_addr_o,
  input logic [AW-1:0] mem_addr_o
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (per_addr_o == $past(per_base_i)) && (mem_addr_o == $past(mem_base_i)));

  // R11
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !per_beat_i) |=> $stable(per_addr_o));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !mem_beat_i) |=> $stable(mem_addr_o));

  // R5
  mem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && mem_beat_i) |=>
      (($countones(mem_addr_o - $past(mem_addr_o)) <= 1) &&
       ((mem_addr_o - $past(mem_addr_o)) <= AW'(4))));

  // R7
  per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && per_beat_i) |=> ((per_addr_o - $past(per_addr_o)) <= AW'(4)));

endmodule

bind dma_stream_addr_gen dsag_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_dma_stream_addr_gen.sv
`timescale 1ns/1ps
module test_dma_stream_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] per_base_i = '0;
  logic [31:0] mem_base_i = '0;
  logic        per_inc_i = 1'b0;
  logic [1:0]  per_size_i = '0;
  logic        per_fixed4_i = 1'b0;
  logic        mem_inc_i = 1'b0;
  logic [1:0]  mem_size_i = '0;
  logic        per_beat_i = 1'b0;
  logic        mem_beat_i = 1'b0;
  logic [31:0] per_addr_o;
  logic [31:0] mem_addr_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  dma_stream_addr_gen i_dma_stream_addr_gen (.*);

  // behavioural reference
  logic [31:0] m_per = '0, m_mem = '0;
  bit m_pinc = 0, m_minc = 0, m_fix = 0;
  int m_psz = 0, m_msz = 0;

  function automatic logic [31:0] adv(logic [31:0] a, bit inc, int sz, bit fix);
    int unsigned delta;
    if (!inc || sz == 3) return a;
    if (fix) return (a & 32'hFFFF_FFFC) + 32'd4;
    delta = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    return a + delta;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per = '0; m_mem = '0; m_pinc = 0; m_minc = 0; m_fix = 0; m_psz = 0; m_msz = 0;
    end else if (start_i) begin
      m_per = per_base_i; m_mem = mem_base_i;
      m_pinc = per_inc_i; m_minc = mem_inc_i; m_fix = per_fixed4_i;
      m_psz = per_size_i; m_msz = mem_size_i;
    end else begin
      if (per_beat_i) m_per = adv(m_per, m_pinc, m_psz, m_fix);
      if (mem_beat_i) m_mem = adv(m_mem, m_minc, m_msz, 1'b0);
    end
    #1;
    if (rst_n) begin
      chk({phase, " model per"}, per_addr_o, m_per);
      chk({phase, " model mem"}, mem_addr_o, m_mem);
    end
  end

  task automatic start(logic [31:0] pb, logic [31:0] mb, bit pi, int ps, bit pf, bit mi, int ms,
                       bit pbeat = 0, bit mbeat = 0);
    @(negedge clk);
    start_i = 1; per_base_i = pb; mem_base_i = mb;
    per_inc_i = pi; per_size_i = 2'(ps); per_fixed4_i = pf;
    mem_inc_i = mi; mem_size_i = 2'(ms);
    per_beat_i = pbeat; mem_beat_i = mbeat;
    @(negedge clk);
    start_i = 0; per_beat_i = 0; mem_beat_i = 0;
  endtask

  task automatic beat(bit p, bit m);
    @(negedge clk);
    per_beat_i = p; mem_beat_i = m;
    @(negedge clk);
    per_beat_i = 0; mem_beat_i = 0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    chk("R1 reset per", per_addr_o, 32'h0);
    chk("R1 reset mem", mem_addr_o, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset per", per_addr_o, 32'h0);
    beat(1, 1);
    chk("R1 idle cfg per", per_addr_o, 32'h0);
    chk("R1 idle cfg mem", mem_addr_o, 32'h0);

    phase = "R2";
    start(32'h1000_0003, 32'h2000_0001, 1, 0, 0, 1, 2);
    chk("R2 load per", per_addr_o, 32'h1000_0003);
    chk("R2 load mem", mem_addr_o, 32'h2000_0001);

    phase = "R3";
    per_size_i = 2'b10; mem_inc_i = 0; per_fixed4_i = 1;
    beat(1, 0);
    chk("R3 per keeps byte step", per_addr_o, 32'h1000_0004);
    chk("R9 mem untouched", mem_addr_o, 32'h2000_0001);
    beat(0, 1);
    chk("R3 mem keeps word step", mem_addr_o, 32'h2000_0005);

    phase = "R9";
    beat(1, 1);
    chk("R9 both per", per_addr_o, 32'h1000_0005);
    chk("R9 both mem", mem_addr_o, 32'h2000_0009);

    phase = "R11";
    @(negedge clk);
    per_beat_i = 1;
    #1;
    chk("R11 pre-beat address", per_addr_o, 32'h1000_0005);
    @(negedge clk);
    per_beat_i = 0;
    chk("R11 post-beat address", per_addr_o, 32'h1000_0006);

    phase = "R4";
    start(32'h40, 32'h80, 1, 1, 0, 0, 2);
    beat(1, 1);
    beat(1, 1);
    chk("R5 half step", per_addr_o, 32'h44);
    chk("R4 mem fixed", mem_addr_o, 32'h80);

    phase = "R2";
    start(32'h100, 32'h200, 1, 0, 0, 1, 0, 1, 1);
    chk("R2 start beats start", per_addr_o, 32'h100);
    chk("R2 start beats start mem", mem_addr_o, 32'h200);

    phase = "R7";
    start(32'h1001, 32'h3000, 1, 0, 1, 1, 1);
    beat(1, 1);
    chk("R7 align step", per_addr_o, 32'h1004);
    chk("R8 mem half step", mem_addr_o, 32'h3002);
    beat(1, 0);
    chk("R7 second step", per_addr_o, 32'h1008);

    phase = "R8";
    start(32'h1001, 32'h3000, 0, 2, 1, 1, 2);
    beat(1, 1);
    chk("R8 fixed without inc", per_addr_o, 32'h1001);
    chk("R8 mem word", mem_addr_o, 32'h3004);

    phase = "R6";
    start(32'h55, 32'h77, 1, 3, 1, 1, 3);
    beat(1, 1);
    chk("R6 reserved per", per_addr_o, 32'h55);
    chk("R6 reserved mem", mem_addr_o, 32'h77);

    phase = "R10";
    start(32'hFFFF_FFFE, 32'hFFFF_FFFC, 1, 1, 0, 1, 2);
    beat(1, 1);
    chk("R10 per wrap", per_addr_o, 32'h0);
    chk("R10 mem wrap", mem_addr_o, 32'h0);
    start(32'hFFFF_FFFF, 32'h0, 1, 0, 1, 1, 0);
    beat(1, 0);
    chk("R10 fixed wrap", per_addr_o, 32'h0);

    phase = "R3 R9 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start_i = ($urandom_range(0, 19) == 0);
      per_base_i = $urandom; mem_base_i = $urandom;
      per_inc_i = $urandom_range(0, 1); per_size_i = 2'($urandom_range(0, 3));
      per_fixed4_i = $urandom_range(0, 1);
      mem_inc_i = $urandom_range(0, 1); mem_size_i = 2'($urandom_range(0, 3));
      per_beat_i = $urandom_range(0, 1); mem_beat_i = $urandom_range(0, 1);
    end
    @(negedge clk);
    start_i = 0; per_beat_i = 0; mem_beat_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule